// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This block gathers interrupt requests from a parameterised set of sources plus one non-maskable line and hands a single prioritised request, with its vector address and source number, to a small processor core. Each source is configured through a register port. It can be edge-detected or level-detected, and the level path has a minimum-hold filter that rejects short glitches. Each source is assigned to either the high or the low priority level. Each source also chooses whether repeated assertions are counted or ignored while a request is outstanding.

Requests are offered to the core only when the core pulses its instruction-boundary strobe. A delivered request marks its level as in service. The core ends the innermost service with a return strobe. A pending request is never cleared by delivery. Software removes it by writing an acknowledge bit. A high-level request may interrupt a low-level service. A low-level request waits until no service is active.

Top module: `irq_ctl`

## Requirements
- R1: After reset all pending state and counters are zero, register 0 (source enables) reads 0 so every source is masked, register 1 (1 = level mode) and register 3 (1 = count mode) read 0, register 2 (1 = high level) reads 0, register 4 reads 3 (bit 0 low-level enable, bit 1 high-level enable, bit 2 low service active, bit 3 high service active), register 5 (filter threshold) reads 2, irq_o is low and irq_vec_o is 0.
- R2: In edge mode a rising edge on a source line makes that source pending; register 6 bit i shows source i pending and bit NSRC shows the non-maskable input pending.
- R3: In level mode a source becomes pending only after its line has been sampled high on at least the threshold (register 5, 0 treated as 1) of consecutive clocks; a shorter high is discarded, and one unbroken high counts as a single assertion.
- R4: A pending request stays set through delivery and return and is delivered again until software writes 1 to its bit of register 6, which is the acknowledge.
- R5: In ignore mode, extra assertions while a source is pending are dropped: its counter (register 8+i) stays at 1, and one acknowledge clears it.
- R6: In count mode the counter counts assertions and saturates at 2^CNT_W-1; each acknowledge subtracts one, and the source stays pending while the counter is non-zero.
- R7: A high-level delivery presents vector 0x0008 and a low-level delivery presents vector 0x0018; 0x0000 is never presented for a delivery.
- R8: A request reaches the core only in the clock after a cycle with boundary_i high; irq_o is then high for that clock with the vector and source number.
- R9: A source whose enable bit is 0 stays pending but is not delivered; the non-maskable input is delivered as a high-level request with source number NSRC regardless of enables, and it takes precedence over every other source.
- R10: Within a level the lowest-numbered eligible source wins; a high request preempts an active low service, a low request is held while any service is active, and no second request of the active level is delivered until ret_i ends that service (ret_i ends the high service first if both are active).
- R11: Clearing a level's global enable bit keeps its requests pending but stops their delivery; setting it again allows delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Maskable request lines |
| nmi_i | input | 1 | Non-maskable request line (edge) |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| ret_i | input | 1 | End of the innermost active service |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq_o | output | 1 | One-clock delivery pulse |
| irq_hi_o | output | 1 | Delivered request is high level |
| irq_id_o | output | IDW | Delivered source number (NSRC for the non-maskable input) |
| irq_vec_o | output | VW | Delivered vector address |

## Verification
The hardest situation to reach is two nested services: a low service in progress, a high request preempting it, and further low and high requests arriving while both levels are marked active. Unwinding with returns in the right order is also part of it. The directed part of the stimulus builds this step by step. It delivers a low request, raises a high source, strobes the boundary again, and then checks that each later strobe is refused or accepted as each return lifts a level. Saturating counters are reached through random bursts of up to nine pulses per source, which also stack across rounds with random acknowledge counts between them.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int NSRC     = 8,
  parameter int CNT_W    = 3,
  parameter int FILT_W   = 4,
  parameter int FILT_RST = 2,
  parameter int VW       = 16,
  parameter logic [VW-1:0] VEC_HI = 'h0008,
  parameter logic [VW-1:0] VEC_LO = 'h0018,
  parameter int DW  = (NSRC + 1 > FILT_W) ? NSRC + 1 : FILT_W,
  parameter int AW  = $clog2(8 + NSRC),
  parameter int IDW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            nmi_i,
  input  logic            boundary_i,
  input  logic            ret_i,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o,
  output logic            irq_hi_o,
  output logic [IDW-1:0]  irq_id_o,
  output logic [VW-1:0]   irq_vec_o
);
  localparam logic [AW-1:0] A_ENA  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_PRIO = AW'(2);
  localparam logic [AW-1:0] A_QUE  = AW'(3);
  localparam logic [AW-1:0] A_GLB  = AW'(4);
  localparam logic [AW-1:0] A_FILT = AW'(5);
  localparam logic [AW-1:0] A_PEND = AW'(6);

  logic [NSRC-1:0]   ena_q, lvl_q, hi_q, que_q;
  logic              en_lo_q, en_hi_q;
  logic [FILT_W-1:0] thr_q, thr_eff;
  logic [NSRC-1:0]   s1_q, s2_q;
  logic              n1_q, n2_q, nmi_pend_q;
  logic [FILT_W-1:0] hold_q [NSRC];
  logic [CNT_W-1:0]  cnt_q  [NSRC];
  logic [NSRC-1:0]   pend;
  logic [NSRC:0]     ack;
  logic              act_hi_q, act_lo_q;
  logic [NSRC-1:0]   elig_hi, elig_lo;
  logic [IDW-1:0]    sel_hi, sel_lo, hi_id;
  logic              go_hi, go_lo;

  assign ack     = (reg_we && reg_addr == A_PEND) ? reg_wdata[NSRC:0] : '0;
  assign thr_eff = (thr_q == '0) ? FILT_W'(1) : thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q   <= '0;
      lvl_q   <= '0;
      hi_q    <= '0;
      que_q   <= '0;
      en_lo_q <= 1'b1;
      en_hi_q <= 1'b1;
      thr_q   <= FILT_W'(FILT_RST);
    end else if (reg_we) begin
      case (reg_addr)
        A_ENA:  ena_q <= reg_wdata[NSRC-1:0];
        A_MODE: lvl_q <= reg_wdata[NSRC-1:0];
        A_PRIO: hi_q  <= reg_wdata[NSRC-1:0];
        A_QUE:  que_q <= reg_wdata[NSRC-1:0];
        A_GLB:  {en_hi_q, en_lo_q} <= reg_wdata[1:0];
        A_FILT: thr_q <= reg_wdata[FILT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0;
      n1_q <= 1'b0; n2_q <= 1'b0; nmi_pend_q <= 1'b0;
    end else begin
      s1_q <= src_i; s2_q <= s1_q;
      n1_q <= nmi_i; n2_q <= n1_q;
      nmi_pend_q <= (nmi_pend_q & ~ack[NSRC]) | (n1_q & ~n2_q);
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic             ev;
    logic [CNT_W-1:0] lim, dec;
    assign ev  = lvl_q[i] ? (s1_q[i] && hold_q[i] == thr_eff - FILT_W'(1))
                          : (s1_q[i] & ~s2_q[i]);
    assign lim = que_q[i] ? '1 : CNT_W'(1);
    assign dec = (ack[i] && cnt_q[i] != '0) ? (que_q[i] ? cnt_q[i] - CNT_W'(1) : '0)
                                             : cnt_q[i];
    assign pend[i] = cnt_q[i] != '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q[i] <= '0;
        cnt_q[i]  <= '0;
      end else begin
        if (!s1_q[i])           hold_q[i] <= '0;
        else if (hold_q[i] != '1) hold_q[i] <= hold_q[i] + FILT_W'(1);
        cnt_q[i] <= (ev && dec < lim) ? dec + CNT_W'(1) : dec;
      end
    end
  end

  assign elig_hi = pend & ena_q & hi_q  & {NSRC{en_hi_q}};
  assign elig_lo = pend & ena_q & ~hi_q & {NSRC{en_lo_q}};

  always_comb begin
    sel_hi = '0;
    sel_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) sel_hi = IDW'(i);
      if (elig_lo[i]) sel_lo = IDW'(i);
    end
  end

  assign hi_id = nmi_pend_q ? IDW'(NSRC) : sel_hi;
  assign go_hi = boundary_i && !act_hi_q && (nmi_pend_q || |elig_hi);
  assign go_lo = boundary_i && !act_hi_q && !act_lo_q && |elig_lo && !go_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_hi_q  <= 1'b0;
      act_lo_q  <= 1'b0;
      irq_o     <= 1'b0;
      irq_hi_o  <= 1'b0;
      irq_id_o  <= '0;
      irq_vec_o <= '0;
    end else begin
      act_hi_q <= go_hi | (act_hi_q & ~ret_i);
      act_lo_q <= go_lo | (act_lo_q & ~(ret_i & ~act_hi_q));
      irq_o    <= go_hi | go_lo;
      if (go_hi) begin
        irq_hi_o  <= 1'b1;
        irq_id_o  <= hi_id;
        irq_vec_o <= VEC_HI;
      end else if (go_lo) begin
        irq_hi_o  <= 1'b0;
        irq_id_o  <= sel_lo;
        irq_vec_o <= VEC_LO;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENA:  reg_rdata = DW'(ena_q);
      A_MODE: reg_rdata = DW'(lvl_q);
      A_PRIO: reg_rdata = DW'(hi_q);
      A_QUE:  reg_rdata = DW'(que_q);
      A_GLB:  reg_rdata = DW'({act_hi_q, act_lo_q, en_hi_q, en_lo_q});
      A_FILT: reg_rdata = DW'(thr_q);
      A_PEND: reg_rdata = DW'({nmi_pend_q, pend});
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (reg_addr == AW'(8 + i)) reg_rdata = DW'(cnt_q[i]);
      end
    endcase
  end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int NSRC = 8,
  parameter int VW   = 16,
  parameter logic [VW-1:0] VEC_HI = 'h0008,
  parameter logic [VW-1:0] VEC_LO = 'h0018
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary_i,
  input logic          irq_o,
  input logic          irq_hi_o,
  input logic [VW-1:0] irq_vec_o,
  input logic          act_hi_q,
  input logic          act_lo_q,
  input logic [NSRC:0] pend_all,
  input logic [NSRC:0] ack
);
  p_vec_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_vec_o == (irq_hi_o ? VEC_HI : VEC_LO)));

  p_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(boundary_i));

  p_lo_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_hi_o) |-> (!$past(act_hi_q) && !$past(act_lo_q)));

  p_hi_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_hi_o) |-> !$past(act_hi_q));

  for (genvar i = 0; i <= NSRC; i++) begin : g_sticky
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_all[i]) |-> $past(ack[i]));
  end
endmodule

bind irq_ctl irq_ctl_chk #(.NSRC(NSRC), .VW(VW), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .irq_o(irq_o),
  .irq_hi_o(irq_hi_o), .irq_vec_o(irq_vec_o), .act_hi_q(act_hi_q),
  .act_lo_q(act_lo_q), .pend_all({nmi_pend_q, pend}), .ack(ack));

// File: tb/irq_ctl_test.sv
module irq_ctl_test;
  localparam int NSRC = 8;
  localparam int DW   = 9;
  localparam int AW   = 4;
  localparam int IDW  = 4;
  localparam int CMAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic nmi_i = 1'b0, boundary_i = 1'b0, ret_i = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_o, irq_hi_o;
  logic [IDW-1:0] irq_id_o;
  logic [15:0] irq_vec_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int v, gi, gh, gd, gv;
  int cnt [NSRC];
  int nn [NSRC];
  int kk [NSRC];

  always #4 clk = ~clk;

  irq_ctl uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .nmi_i(nmi_i),
    .boundary_i(boundary_i), .ret_i(ret_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_hi_o(irq_hi_o),
    .irq_id_o(irq_id_o), .irq_vec_o(irq_vec_o));

  function automatic int sat_add(int c, int n);
    return (c + n > CMAX) ? CMAX : c + n;
  endfunction
  function automatic int sub0(int c, int k);
    return (c > k) ? c - k : 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int val);
    @(negedge clk); reg_addr = AW'(a); #1 val = int'(reg_rdata);
  endtask

  task automatic pulse(int bits);
    @(negedge clk); src_i = src_i | NSRC'(bits);
    @(negedge clk); src_i = src_i & ~NSRC'(bits);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); boundary_i = 1'b1;
    @(negedge clk); boundary_i = 1'b0;
    gi = int'(irq_o); gh = int'(irq_hi_o); gd = int'(irq_id_o); gv = int'(irq_vec_o);
  endtask

  task automatic do_ret();
    @(negedge clk); ret_i = 1'b1;
    @(negedge clk); ret_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=0 exp=1");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    rd(0, v); chk("R1 enables", v, 0);
    rd(1, v); chk("R1 mode", v, 0);
    rd(2, v); chk("R1 prio", v, 0);
    rd(3, v); chk("R1 queue", v, 0);
    rd(4, v); chk("R1 global", v, 3);
    rd(5, v); chk("R1 filter", v, 2);
    rd(6, v); chk("R1 pending", v, 0);
    rd(8, v); chk("R1 counter", v, 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 vector", int'(irq_vec_o), 0);

    // R2 edge, R9 masked source stays pending
    pulse(1); settle();
    rd(6, v); chk("R2 edge pending", v, 1);
    rd(8, v); chk("R5 ignore count", v, 1);
    strobe(); chk("R9 masked no irq", gi, 0);

    // R8 no delivery without a boundary strobe
    wr(0, 1); settle();
    chk("R8 no strobe no irq", int'(irq_o), 0);
    strobe();
    chk("R8 delivered", gi, 1);
    chk("R7 low vector", gv, 'h18);
    chk("R10 low level", gh, 0);
    chk("R8 source id", gd, 0);
    rd(6, v); chk("R4 sticky after delivery", v, 1);
    strobe(); chk("R10 no redelivery in service", gi, 0);
    do_ret();
    strobe(); chk("R4 redelivered until ack", gi, 1);
    do_ret();
    wr(6, 1);
    rd(6, v); chk("R4 ack clears", v, 0);

    // R5 ignore mode
    pulse(1); pulse(1); pulse(1); settle();
    rd(8, v); chk("R5 ignore holds one", v, 1);
    wr(6, 1);
    rd(8, v); chk("R5 one ack clears", v, 0);

    // R3 level filter, threshold 3
    wr(1, 2); wr(5, 3);
    @(negedge clk); src_i[1] = 1'b1;
    repeat (2) @(negedge clk); src_i[1] = 1'b0;
    settle();
    rd(6, v); chk("R3 short glitch dropped", v, 0);
    @(negedge clk); src_i[1] = 1'b1;
    repeat (3) @(negedge clk); src_i[1] = 1'b0;
    settle();
    rd(6, v); chk("R3 held level accepted", v, 2);
    wr(6, 2); wr(3, 2);
    @(negedge clk); src_i[1] = 1'b1;
    repeat (10) @(negedge clk); src_i[1] = 1'b0;
    settle();
    rd(9, v); chk("R3 long level counts once", v, 1);
    wr(6, 2); wr(1, 0);

    // R6 count mode
    wr(3, 8);
    pulse(8); pulse(8); pulse(8); settle();
    rd(11, v); chk("R6 count three", v, 3);
    wr(6, 8);
    rd(11, v); chk("R6 ack decrements", v, 2);
    rd(6, v); chk("R6 still pending", v, 8);
    wr(6, 8); wr(6, 8);
    rd(11, v); chk("R6 drained", v, 0);
    rd(6, v); chk("R6 not pending", v, 0);
    for (int j = 0; j < 10; j++) pulse(8);
    settle();
    rd(11, v); chk("R6 saturates", v, CMAX);
    wr(6, 8);
    rd(11, v); chk("R6 after sat ack", v, CMAX - 1);

    // R10 priority and preemption
    do_reset();
    wr(0, 'hFF); wr(2, 'h30);
    pulse('h70); settle();
    strobe();
    chk("R10 lowest high wins", gd, 4);
    chk("R7 high vector", gv, 'h08);
    wr(6, 'h10); do_ret();
    strobe(); chk("R10 next high", gd, 5);
    wr(6, 'h20); do_ret();
    strobe(); chk("R10 low after highs", gd, 6);
    chk("R7 low vector again", gv, 'h18);
    pulse('h80); settle();
    strobe(); chk("R10 low held in low service", gi, 0);
    pulse('h10); settle();
    strobe();
    chk("R10 high preempts low", gi, 1);
    chk("R10 preempt id", gd, 4);
    rd(4, v); chk("R10 both active", v, 'hF);
    strobe(); chk("R10 low held in high service", gi, 0);
    do_ret();
    rd(4, v); chk("R10 ret ends high first", v, 7);
    wr(6, 'h10); do_ret();
    strobe(); chk("R10 unacked low returns", gd, 6);
    wr(6, 'hC0); do_ret();

    // R11 global enables
    wr(4, 1);
    pulse('h10); settle();
    strobe(); chk("R11 high disabled", gi, 0);
    rd(6, v); chk("R11 kept pending", v, 'h10);
    wr(4, 3);
    strobe(); chk("R11 high reenabled", gi, 1);
    wr(6, 'h10); do_ret();
    wr(4, 2);
    pulse('h40); settle();
    strobe(); chk("R11 low disabled", gi, 0);
    wr(4, 3);
    strobe(); chk("R11 low reenabled id", gd, 6);
    wr(6, 'h40); do_ret();

    // R9 non-maskable input
    wr(0, 0); wr(4, 0);
    @(negedge clk); nmi_i = 1'b1;
    @(negedge clk); nmi_i = 1'b0;
    settle();
    rd(6, v); chk("R9 nmi pending", v, 'h100);
    strobe();
    chk("R9 nmi delivered", gi, 1);
    chk("R9 nmi high", gh, 1);
    chk("R9 nmi id", gd, NSRC);
    chk("R7 nmi vector", gv, 'h08);
    wr(6, 'h100); do_ret();
    rd(6, v); chk("R4 nmi ack", v, 0);

    // R6 random bursts in count mode
    do_reset();
    wr(3, 'hFF);
    for (int i = 0; i < NSRC; i++) cnt[i] = 0;
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < NSRC; i++) nn[i] = int'($urandom_range(0, 9));
      for (int s = 0; s < 9; s++) begin
        int b;
        b = 0;
        for (int i = 0; i < NSRC; i++) if (nn[i] > s) b = b | (1 << i);
        pulse(b);
      end
      settle();
      for (int i = 0; i < NSRC; i++) begin
        cnt[i] = sat_add(cnt[i], nn[i]);
        rd(8 + i, v); chk("R6 random count", v, cnt[i]);
      end
      for (int i = 0; i < NSRC; i++) kk[i] = int'($urandom_range(0, 3));
      for (int j = 0; j < 3; j++) begin
        int b;
        b = 0;
        for (int i = 0; i < NSRC; i++) if (kk[i] > j) b = b | (1 << i);
        wr(6, b);
      end
      begin
        int pe;
        pe = 0;
        for (int i = 0; i < NSRC; i++) begin
          cnt[i] = sub0(cnt[i], kk[i]);
          if (cnt[i] != 0) pe = pe | (1 << i);
          rd(8 + i, v); chk("R6 random after ack", v, cnt[i]);
        end
        rd(6, v); chk("R6 random pending", v, pe);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule